// File: doc/BRIEF.md
# Mixed-Width Integer Execution Lane

This block is a purely combinational execution lane for one integer element whose two source operands and destination each carry an independent 2-bit width code. It decodes the codes to bit widths, extends each source from its own width, and performs the selected operation at the larger of the two source widths. It then fits the result to the destination width and produces a byte-lane write enable that a register file can use to merge the element into a wider register.

The lane has no storage. A result and its valid flag appear in the same cycle as the operands. An issue stage drives the lane once per element, and the surrounding loop supplies the per-element operand slices. The caller also supplies a flag that says whether the destination is treated as a vector element, which keeps untouched bytes, or as a scalar register, which is filled to full width.

Top module: `elw_alu_lane`

## Requirements
- R1: Width codes decode as 0 = XLEN (parameter, 32 or 64), 1 = 8 bits, 2 = 16 bits, 3 = 32 bits, for both sources and the destination.
- R2: The operation width is the larger of the two decoded source widths. The destination width never changes the operation result before fitting.
- R3: Opcode encoding: 0 add, 1 add-word, 2 shift left, 3 logical shift right, 4 arithmetic shift right, 5 signed multiply-high, 6 unsigned multiply-high, 7 reserved. Add zero-extends each source from its own width, and add-word sign-extends each source. The sum wraps at the operation width.
- R4: For opcodes 2 to 4, the shift amount is source 2 ANDed with (operation width - 1). Source 1 is sign-extended for the arithmetic shift and zero-extended otherwise. The shifted value is taken at the operation width.
- R5: Multiply-high forms the full product of both sources, each extended to the operation width (signed for opcode 5, unsigned for opcode 6), and returns the product shifted down by the operation width.
- R6: Destination fitting happens after the operation. A wider destination extends the operation-width result, with sign extension for opcodes 1, 4 and 5 and zero extension otherwise. A narrower destination keeps only its low bits.
- R7: With the destination flagged scalar, the fitted element is extended from the destination width out to the full XLEN, with sign extension for opcodes 1, 4 and 5 and zero extension otherwise. Every byte enable is then set.
- R8: With the destination flagged vector, bits above the destination width are zero. The byte enables cover exactly the low destination-width bytes, with bit k for byte k.
- R9: out_valid equals in_valid in the same cycle. While in_valid is low, out_data and out_byte_en are zero. Opcode 7 yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Operands present this cycle |
| op_code | input | 3 | Operation select (see R3) |
| src1_data | input | XLEN | First source element, low bits significant |
| src1_wcode | input | 2 | Width code of source 1 |
| src2_data | input | XLEN | Second source element or shift amount |
| src2_wcode | input | 2 | Width code of source 2 |
| dst_wcode | input | 2 | Width code of the destination |
| dst_is_vec | input | 1 | 1 = vector destination, 0 = scalar destination |
| out_valid | output | 1 | Result present, same cycle as in_valid |
| out_data | output | XLEN | Fitted destination value |
| out_byte_en | output | XLEN/8 | Byte-lane write enables for the destination |

## Verification
Operation-width selection and destination fitting act on the same element in the same cycle. The risky case is when the two widths disagree. Directed cases provoke this with an arithmetic shift whose amount is masked by a 16-bit operation width but whose result lands in a scalar 64-bit destination, and with a signed multiply-high whose 8-bit high half is widened into a 16-bit vector element. Each case is judged against an independent 128-bit reference computed in the bench. A pseudo-random sweep over every opcode and code combination, including the reserved opcode, repeats that comparison on both the data and the byte enables.

// File: rtl/elw_pkg.sv
package elw_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDW  = 3'd1,
        OP_SLL   = 3'd2,
        OP_SRL   = 3'd3,
        OP_SRA   = 3'd4,
        OP_MULH  = 3'd5,
        OP_MULHU = 3'd6,
        OP_RSVD  = 3'd7
    } elw_op_e;

    // Width class: element bits = 8 << class
    typedef enum logic [1:0] {
        WC_8  = 2'd0,
        WC_16 = 2'd1,
        WC_32 = 2'd2,
        WC_64 = 2'd3
    } elw_wclass_e;

    function automatic int unsigned wclass_bits(elw_wclass_e c);
        return 32'd8 << c;
    endfunction

    // Keep the low 'bits' of v and fill above them with the top kept bit or zero.
    function automatic logic [63:0] extend64(logic [63:0] v, int unsigned bits, logic sgn);
        logic [63:0] keep;
        logic [5:0]  top;
        logic        fill;
        keep = (bits >= 64) ? '1 : ((64'd1 << bits) - 64'd1);
        top  = 6'(bits - 1);
        fill = sgn & v[top];
        return fill ? (v | ~keep) : (v & keep);
    endfunction

    function automatic logic op_result_signed(elw_op_e op);
        return (op == OP_ADDW) || (op == OP_SRA) || (op == OP_MULH);
    endfunction

endpackage

// File: rtl/elw_width_decode.sv
module elw_width_decode
    import elw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]  src1_code,
    input  logic [1:0]  src2_code,
    input  logic [1:0]  dst_code,
    output elw_wclass_e src1_wc,
    output elw_wclass_e src2_wc,
    output elw_wclass_e dst_wc,
    output elw_wclass_e op_wc
);

    localparam elw_wclass_e XLEN_CLASS = (XLEN == 64) ? WC_64 : WC_32;

    function automatic elw_wclass_e decode_code(logic [1:0] code);
        unique case (code)
            2'd0:    return XLEN_CLASS;
            2'd1:    return WC_8;
            2'd2:    return WC_16;
            default: return WC_32;
        endcase
    endfunction

    always_comb begin
        src1_wc = decode_code(src1_code);
        src2_wc = decode_code(src2_code);
        dst_wc  = decode_code(dst_code);
        op_wc   = (src1_wc > src2_wc) ? src1_wc : src2_wc;
    end

    always_comb begin
        AST_OPW_IS_SOURCE_MAX: assert ((op_wc == src1_wc || op_wc == src2_wc) && op_wc >= src1_wc && op_wc >= src2_wc)
            else $error("operation width is not the larger source width"); // R2
    end

endmodule

// File: rtl/elw_src_extend.sv
module elw_src_extend
    import elw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  elw_wclass_e     wc,
    input  logic            sgn,
    output logic [XLEN-1:0] ext
);

    always_comb begin
        ext = XLEN'(extend64(64'(raw), wclass_bits(wc), sgn));
    end

endmodule

// File: rtl/elw_exec.sv
module elw_exec
    import elw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  elw_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  elw_wclass_e     op_wc,
    output logic [XLEN-1:0] res
);

    localparam int PW = 2 * XLEN;

    int unsigned     opbits;
    logic [5:0]      shamt;
    logic [PW-1:0]   pa;
    logic [PW-1:0]   pb;
    logic [PW-1:0]   prod;
    logic [XLEN-1:0] hi_part;
    logic [XLEN-1:0] raw;

    always_comb begin
        opbits  = wclass_bits(op_wc);
        shamt   = opb[5:0] & 6'(opbits - 1);
        pa      = (op == OP_MULH) ? {{XLEN{opa[XLEN-1]}}, opa} : {{XLEN{1'b0}}, opa};
        pb      = (op == OP_MULH) ? {{XLEN{opb[XLEN-1]}}, opb} : {{XLEN{1'b0}}, opb};
        prod    = pa * pb;
        hi_part = XLEN'(prod >> opbits);
        unique case (op)
            OP_ADD, OP_ADDW:  raw = opa + opb;
            OP_SLL:           raw = opa << shamt;
            OP_SRL:           raw = opa >> shamt;
            OP_SRA:           raw = $signed(opa) >>> shamt;
            OP_MULH, OP_MULHU: raw = hi_part;
            default:          raw = '0;
        endcase
        res = XLEN'(extend64(64'(raw), opbits, 1'b0));
    end

    always_comb begin
        AST_SHAMT_IN_OPW: assert (32'(shamt) < opbits)
            else $error("shift amount exceeds operation width"); // R4
    end

endmodule

// File: rtl/elw_dest_fit.sv
module elw_dest_fit
    import elw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 valid,
    input  logic [XLEN-1:0]      res,
    input  elw_wclass_e          op_wc,
    input  elw_wclass_e          dst_wc,
    input  logic                 sgn,
    input  logic                 dst_vec,
    output logic [XLEN-1:0]      data,
    output logic [XLEN/8-1:0]    byte_en
);

    localparam int BEW = XLEN / 8;

    logic [63:0]     at_opw;
    int unsigned     dbits;
    logic [XLEN-1:0] fitted;
    logic [BEW-1:0]  be_vec;

    always_comb begin
        dbits  = wclass_bits(dst_wc);
        at_opw = extend64(64'(res), wclass_bits(op_wc), sgn);
        fitted = XLEN'(extend64(at_opw, dbits, sgn & ~dst_vec));
        be_vec = BEW'((1 << (dbits / 8)) - 1);
        data    = valid ? fitted : '0;
        byte_en = valid ? (dst_vec ? be_vec : '1) : '0;
    end

endmodule

// File: rtl/elw_alu_lane.sv
module elw_alu_lane
    import elw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 in_valid,
    input  logic [2:0]           op_code,
    input  logic [XLEN-1:0]      src1_data,
    input  logic [1:0]           src1_wcode,
    input  logic [XLEN-1:0]      src2_data,
    input  logic [1:0]           src2_wcode,
    input  logic [1:0]           dst_wcode,
    input  logic                 dst_is_vec,
    output logic                 out_valid,
    output logic [XLEN-1:0]      out_data,
    output logic [XLEN/8-1:0]    out_byte_en
);

    localparam int NSRC = 2;
    localparam int BEW  = XLEN / 8;

    elw_op_e         op;
    elw_wclass_e     src_wc  [NSRC];
    logic [XLEN-1:0] src_raw [NSRC];
    logic [XLEN-1:0] src_ext [NSRC];
    logic            src_sgn [NSRC];
    elw_wclass_e     dst_wc;
    elw_wclass_e     op_wc;
    logic [XLEN-1:0] op_res;
    logic [XLEN-1:0] dst_keep;

    always_comb begin
        op         = elw_op_e'(op_code);
        src_raw[0] = src1_data;
        src_raw[1] = src2_data;
        src_sgn[0] = (op == OP_ADDW) || (op == OP_SRA) || (op == OP_MULH);
        src_sgn[1] = (op == OP_ADDW) || (op == OP_MULH);
    end

    elw_width_decode #(.XLEN(XLEN)) u_decode (
        .src1_code (src1_wcode),
        .src2_code (src2_wcode),
        .dst_code  (dst_wcode),
        .src1_wc   (src_wc[0]),
        .src2_wc   (src_wc[1]),
        .dst_wc    (dst_wc),
        .op_wc     (op_wc)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        elw_src_extend #(.XLEN(XLEN)) u_ext (
            .raw (src_raw[s]),
            .wc  (src_wc[s]),
            .sgn (src_sgn[s]),
            .ext (src_ext[s])
        );
    end

    elw_exec #(.XLEN(XLEN)) u_exec (
        .op    (op),
        .opa   (src_ext[0]),
        .opb   (src_ext[1]),
        .op_wc (op_wc),
        .res   (op_res)
    );

    elw_dest_fit #(.XLEN(XLEN)) u_fit (
        .valid   (in_valid),
        .res     (op_res),
        .op_wc   (op_wc),
        .dst_wc  (dst_wc),
        .sgn     (op_result_signed(op)),
        .dst_vec (dst_is_vec),
        .data    (out_data),
        .byte_en (out_byte_en)
    );

    assign out_valid = in_valid;

    always_comb begin
        dst_keep = XLEN'(extend64('1, wclass_bits(dst_wc), 1'b0));
        if (in_valid && dst_is_vec) begin
            AST_VEC_UPPER_CLEAR: assert ((out_data & ~dst_keep) == '0)
                else $error("vector element has bits above its width"); // R8
        end
        AST_BE_CONTIGUOUS: assert ($onehot0(BEW'(out_byte_en + 1'b1)))
            else $error("byte enables not a low contiguous run"); // R8
        if (in_valid && !dst_is_vec) begin
            AST_SCALAR_BE_FULL: assert (&out_byte_en)
                else $error("scalar destination missing byte enables"); // R7
        end
        if (!in_valid) begin
            AST_IDLE_QUIET: assert (out_data == '0 && out_byte_en == '0)
                else $error("outputs active without valid"); // R9
        end
    end

endmodule

// File: tb/elw_alu_lane_tb_top.sv
`timescale 1ns/1ps
module elw_alu_lane_tb_top;

    localparam int XLEN = 64;
    localparam int BEW  = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid;
    logic [2:0]      op_code;
    logic [XLEN-1:0] src1_data, src2_data;
    logic [1:0]      src1_wcode, src2_wcode, dst_wcode;
    logic            dst_is_vec;
    logic            out_valid;
    logic [XLEN-1:0] out_data;
    logic [BEW-1:0]  out_byte_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 0;

    always #2 clk = ~clk;

    elw_alu_lane #(.XLEN(XLEN)) dut_i (
        .in_valid    (in_valid),
        .op_code     (op_code),
        .src1_data   (src1_data),
        .src1_wcode  (src1_wcode),
        .src2_data   (src2_data),
        .src2_wcode  (src2_wcode),
        .dst_wcode   (dst_wcode),
        .dst_is_vec  (dst_is_vec),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_byte_en (out_byte_en)
    );

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Reference model built from the requirements with 128-bit arithmetic.
    function automatic int code_bits(logic [1:0] c);
        return (c == 2'd0) ? XLEN : (4 << c);
    endfunction

    function automatic logic [127:0] widen(logic [127:0] v, int w, bit s);
        logic [127:0] r;
        for (int i = 0; i < 128; i++)
            r[i] = (i < w) ? v[i] : (s ? v[w-1] : 1'b0);
        return r;
    endfunction

    function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [1:0] ca,
                                          logic [63:0] b, logic [1:0] cb, logic [1:0] cd,
                                          bit vec, output logic [7:0] be);
        int wa = code_bits(ca);
        int wb = code_bits(cb);
        int wd = code_bits(cd);
        int ow = (wa > wb) ? wa : wb;
        bit sres = (op == 3'd1) || (op == 3'd4) || (op == 3'd5);
        bit sb   = (op == 3'd1) || (op == 3'd5);
        logic [127:0] aa = widen({64'd0, a}, wa, sres);
        logic [127:0] bb = widen({64'd0, b}, wb, sb);
        int sh = int'(bb[5:0]) & (ow - 1);
        logic [127:0] r;
        case (op)
            3'd0, 3'd1: r = aa + bb;
            3'd2: r = aa << sh;
            3'd3: r = aa >> sh;
            3'd4: for (int i = 0; i < 128; i++) r[i] = (i + sh < 128) ? aa[i+sh] : aa[127];
            3'd5, 3'd6: r = (aa * bb) >> ow;
            default: r = '0;
        endcase
        r  = widen(r, ow, sres);
        r  = widen(r, wd, sres && !vec);
        be = vec ? 8'((1 << (wd / 8)) - 1) : 8'hFF;
        return r[63:0];
    endfunction

    task automatic drive(logic [2:0] op, logic [63:0] a, logic [1:0] ca,
                         logic [63:0] b, logic [1:0] cb, logic [1:0] cd, bit vec);
        @(negedge clk);
        in_valid   = 1'b1;
        op_code    = op;
        src1_data  = a;
        src1_wcode = ca;
        src2_data  = b;
        src2_wcode = cb;
        dst_wcode  = cd;
        dst_is_vec = vec;
        #1;
    endtask

    task automatic expect_both(string req, logic [63:0] exp_d, logic [7:0] exp_be);
        chk(req, out_data, exp_d);
        chk(req, 64'(out_byte_en), 64'(exp_be));
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0; op_code = 3'd0; src1_data = '1; src2_data = '1;
        src1_wcode = 2'd0; src2_wcode = 2'd0; dst_wcode = 2'd0; dst_is_vec = 1'b0;
        #1;
        chk("R9 idle valid", 64'(out_valid), 64'd0);
        expect_both("R9 idle outputs", 64'd0, 8'h00);
    endtask

    task automatic t_codes;
        drive(3'd0, '1, 2'd1, 64'd0, 2'd0, 2'd0, 1'b0);
        chk("R9 valid follows", 64'(out_valid), 64'd1);
        expect_both("R1 code1 8-bit", 64'hFF, 8'hFF);
        drive(3'd0, '1, 2'd2, 64'd0, 2'd0, 2'd0, 1'b0);
        expect_both("R1 code2 16-bit", 64'hFFFF, 8'hFF);
        drive(3'd0, '1, 2'd3, 64'd0, 2'd0, 2'd0, 1'b0);
        expect_both("R1 code3 32-bit", 64'hFFFF_FFFF, 8'hFF);
        drive(3'd0, '1, 2'd0, 64'd1, 2'd1, 2'd0, 1'b0);
        expect_both("R1 code0 XLEN", 64'd0, 8'hFF);
    endtask

    task automatic t_opwidth;
        drive(3'd0, 64'hFF, 2'd1, 64'h01, 2'd1, 2'd3, 1'b1);
        expect_both("R2 8-bit wrap", 64'h0, 8'h0F);
        drive(3'd0, 64'hFF, 2'd1, 64'h0001, 2'd2, 2'd3, 1'b1);
        expect_both("R2 max source 16", 64'h100, 8'h0F);
    endtask

    task automatic t_addw;
        drive(3'd1, 64'h80, 2'd1, 64'h0001, 2'd2, 2'd3, 1'b1);
        expect_both("R3 addw sign-extend", 64'hFFFF_FF81, 8'h0F);
        drive(3'd0, 64'h80, 2'd1, 64'h0001, 2'd2, 2'd3, 1'b1);
        expect_both("R3 add zero-extend", 64'h0081, 8'h0F);
    endtask

    task automatic t_shift;
        drive(3'd2, 64'h0001, 2'd2, 64'h11, 2'd1, 2'd0, 1'b0);
        expect_both("R4 sll masked to 15", 64'h2, 8'hFF);
        drive(3'd4, 64'h8000, 2'd2, 64'h14, 2'd1, 2'd0, 1'b0);
        expect_both("R4 sra masked, scalar fill", 64'hFFFF_FFFF_FFFF_F800, 8'hFF);
        drive(3'd3, 64'h8000, 2'd2, 64'h14, 2'd1, 2'd0, 1'b0);
        expect_both("R4 srl masked", 64'h0800, 8'hFF);
    endtask

    task automatic t_mulh;
        drive(3'd6, 64'hFFFF_FFFF, 2'd3, 64'hFF, 2'd1, 2'd3, 1'b1);
        expect_both("R5 mulhu 32x8", 64'hFE, 8'h0F);
        drive(3'd5, 64'h80, 2'd1, 64'h02, 2'd1, 2'd2, 1'b1);
        expect_both("R5 mulh signed into wider dest", 64'hFFFF, 8'h03);
    endtask

    task automatic t_fit;
        drive(3'd0, 64'h1234_5678, 2'd3, 64'd0, 2'd1, 2'd1, 1'b1);
        expect_both("R6 truncate to 8", 64'h78, 8'h01);
        drive(3'd1, 64'h7FFF, 2'd2, 64'h1, 2'd2, 2'd2, 1'b0);
        expect_both("R7 scalar sign fill", 64'hFFFF_FFFF_FFFF_8000, 8'hFF);
        drive(3'd1, 64'h7FFF, 2'd2, 64'h1, 2'd2, 2'd2, 1'b1);
        expect_both("R8 vector keeps width", 64'h8000, 8'h03);
        drive(3'd7, 64'h55, 2'd1, 64'h66, 2'd1, 2'd1, 1'b1);
        chk("R9 reserved op zero", out_data, 64'd0);
    endtask

    task automatic t_sweep;
        logic [63:0] st = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a, b, e;
            logic [7:0]  be;
            logic [9:0]  sel;
            st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
            a = st;
            st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
            b = st;
            sel = st[9:0];
            drive(sel[2:0], a, sel[4:3], b, sel[6:5], sel[8:7], sel[9]);
            e = model(sel[2:0], a, sel[4:3], b, sel[6:5], sel[8:7], sel[9], be);
            expect_both("R6 R7 R8 sweep", e, be);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        in_valid = 1'b0; op_code = '0; src1_data = '0; src2_data = '0;
        src1_wcode = '0; src2_wcode = '0; dst_wcode = '0; dst_is_vec = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_codes();
        t_opwidth();
        t_addw();
        t_shift();
        t_mulh();
        t_fit();
        t_sweep();
        t_idle();
        report();
        $finish;
    end

endmodule